// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serialises characters onto an asynchronous serial line. A host places a character into a one-entry holding register. When the transmit shift register is free, the engine moves the character into it and sends the frame: a low start bit, 7 or 8 data bits least-significant first, an optional even or odd parity bit, then one or two high stop bits. Each bit lasts sixteen periods of an external baud tick. Baud-rate division is done outside the block.

The holding register lets the host queue the next character while the current one is still shifting out. Two flags report progress. The buffer-empty flag means the holding register can take a new character. The shift-complete flag means no frame is in flight. A transmit interrupt pulse follows one of these two flags, and the host picks which one.

From idle, a write does not start a frame at once. The frame starts on an internal bit boundary that lies between half a bit and one and a half bits after the write. Frames queued while a frame is running go out back to back, with no idle bit between them.

Top module: `dbuf_uart_tx`

## Requirements
- R1: While reset is held and in the cycle after it is released, `txd` is 1, `buf_empty` is 1, `shift_done` is 1 and `tx_irq` is 0.
- R2: A frame consists of the following bits, in this order:
  - one start bit at 0;
  - the data bits, least-significant first: `wr_data[6:0]` when `cfg_len8`=0, or `wr_data[7:0]` when `cfg_len8`=1;
  - a parity bit, only when `cfg_parity_en`=1;
  - stop bits at 1: one stop bit when `cfg_stop2`=0, two when `cfg_stop2`=1.
  
  Every bit lasts 16 baud ticks. `txd` is 1 while idle.
- R3: The parity bit is chosen so that the count of ones over the sent data bits plus the parity bit is even when `cfg_parity_odd`=0 and odd when `cfg_parity_odd`=1.
- R4: `buf_empty` reads 0 from the cycle after an accepted write. It returns to 1 in the same cycle that the held character enters the shift register, which is also the cycle the start bit appears on `txd`.
- R5: A write while `buf_empty` is 0 replaces the pending character. Only the last written character is sent.
- R6: `shift_done` is 1 while idle and 0 from the start bit onward. With one stop bit it returns to 1 after that stop bit. With two stop bits it is 1 for the whole second stop bit. Whenever `shift_done` is 1, `txd` is 1.
- R7: From idle, the start bit and the fall of `shift_done` come at the first bit boundary that follows a mid-bit instant at which the buffer already held the character. With a tick every clock, this is 9 to 24 clocks after the write clock. This places the start between 0.5 and 1.5 bit times after the write.
- R8: If the buffer holds a character when the last stop bit of a frame ends, the next start bit follows that stop bit directly. With one stop bit, `shift_done` stays 0 across the frame junction.
- R9: `tx_irq` is a one-clock pulse in the first cycle in which the selected flag is 1 after being 0. The selected flag is `buf_empty` when `cfg_irq_on_done`=0 and `shift_done` when `cfg_irq_on_done`=1.
- R10: Progress depends only on baud ticks. While `baud_tick` stays 0 the line and the flags hold their values, and a bit lasts 16 ticks whatever the spacing of the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Enable at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_irq_on_done | input | 1 | Interrupt source: 1 shift-complete, 0 buffer-empty |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register can take a character |
| shift_done | output | 1 | No frame in flight |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
The hardest situation to reach is the start-latency window. The write has to land at every phase of the free-running internal bit counter, including the phases just before and just after the mid-bit instant that decides between a short and a long wait. The sweep inserts a delay of a different number of clocks before each of its 128 writes, so that the writes fall across all sixteen phases. It measures the clocks from write to the fall of `shift_done` against the window. Back-to-back frames are reached by writing the second character in the first cycle of the first frame's start bit, and a stalled tick is held in the middle of a start bit.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } frame_state_e;

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } frame_cfg_t;

    // Parity bit over the bits that are actually sent.
    function automatic logic frame_parity(input logic [DATA_W-1:0] d,
                                          input logic len8,
                                          input logic odd);
        logic [DATA_W-1:0] m;
        m = len8 ? d : {1'b0, d[DATA_W-2:0]};
        return (^m) ^ odd;
    endfunction

endpackage

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic bit_edge,
    output logic bit_mid
);
    localparam int PW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [PW-1:0] LAST = PW'(OVERSAMPLE - 1);
    localparam logic [PW-1:0] MID  = PW'(OVERSAMPLE / 2 - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign bit_edge = tick && (phase == LAST);
    assign bit_mid  = tick && (phase == MID);
endmodule

// File: rtl/utx_hold_buf.sv
module utx_hold_buf
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_mid,
    input  logic              take,
    output logic [DATA_W-1:0] data_q,
    output logic              full,
    output logic              armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full   <= 1'b0;
            armed  <= 1'b0;
        end else begin
            if (wr_en) begin
                data_q <= wr_data;
            end
            if (wr_en) begin
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
            // A character must have been held across a mid-bit instant
            // before an idle engine may pick it up.
            if (take) begin
                armed <= 1'b0;
            end else if (bit_mid && full) begin
                armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_edge,
    input  frame_cfg_t        cfg,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_full,
    input  logic              hold_armed,
    output logic              take,
    output logic              txd,
    output logic              shift_done
);
    frame_state_e      state;
    logic [DATA_W-1:0] sh;
    logic [2:0]        bit_idx;
    logic              par_bit;
    logic              second_stop;
    logic              last_stop;
    logic [2:0]        last_idx;

    assign last_idx  = cfg.len8 ? 3'd7 : 3'd6;
    assign last_stop = (state == ST_STOP) && (second_stop || !cfg.stop2);
    assign take      = bit_edge && hold_full &&
                       (((state == ST_IDLE) && hold_armed) || last_stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            sh          <= '0;
            bit_idx     <= '0;
            par_bit     <= 1'b0;
            second_stop <= 1'b0;
        end else if (take) begin
            state       <= ST_START;
            sh          <= hold_data;
            par_bit     <= frame_parity(hold_data, cfg.len8, cfg.par_odd);
            bit_idx     <= '0;
            second_stop <= 1'b0;
        end else if (bit_edge) begin
            case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    sh      <= sh >> 1;
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == last_idx) begin
                        state <= cfg.par_en ? ST_PARITY : ST_STOP;
                    end
                end
                ST_PARITY: state <= ST_STOP;
                ST_STOP: begin
                    if (cfg.stop2 && !second_stop) begin
                        second_stop <= 1'b1;
                    end else begin
                        state       <= ST_IDLE;
                        second_stop <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh[0];
            ST_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end

    assign shift_done = (state == ST_IDLE) || ((state == ST_STOP) && second_stop);
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import utx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_len8,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_stop2,
    input  logic              cfg_irq_on_done,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_done,
    output logic              tx_irq
);
    logic              bit_edge;
    logic              bit_mid;
    logic              take;
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              hold_armed;
    logic              empty_q;
    logic              done_q;
    frame_cfg_t        cfg;

    assign cfg = '{len8: cfg_len8, par_en: cfg_parity_en,
                   par_odd: cfg_parity_odd, stop2: cfg_stop2};

    utx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk(clk), .rst(rst), .tick(baud_tick),
        .bit_edge(bit_edge), .bit_mid(bit_mid)
    );

    utx_hold_buf u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .bit_mid(bit_mid), .take(take),
        .data_q(hold_data), .full(hold_full), .armed(hold_armed)
    );

    utx_framer u_framer (
        .clk(clk), .rst(rst), .bit_edge(bit_edge), .cfg(cfg),
        .hold_data(hold_data), .hold_full(hold_full), .hold_armed(hold_armed),
        .take(take), .txd(txd), .shift_done(shift_done)
    );

    assign buf_empty = !hold_full;

    // Edge detection on both flags; reset to 1 so release gives no pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            done_q  <= 1'b1;
        end else begin
            empty_q <= buf_empty;
            done_q  <= shift_done;
        end
    end

    assign tx_irq = cfg_irq_on_done ? (shift_done && !done_q)
                                    : (buf_empty && !empty_q);
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic cfg_irq_on_done,
    input logic txd,
    input logic buf_empty,
    input logic shift_done,
    input logic tx_irq
);
    assert_write_fills_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !buf_empty);

    assert_load_starts_frame_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_empty) |-> !shift_done);

    assert_done_line_high_R6: assert property (@(posedge clk) disable iff (rst)
        shift_done |-> txd);

    assert_start_bit_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_done) |-> !txd);

    assert_irq_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> (cfg_irq_on_done ? $rose(shift_done) : $rose(buf_empty)));
endmodule

bind dbuf_uart_tx utx_checker u_utx_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cfg_irq_on_done(cfg_irq_on_done),
    .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .tx_irq(tx_irq)
);

// File: tb/dbuf_uart_tx_bench.sv
`timescale 1ns/1ps
module dbuf_uart_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       c_len8 = 1'b1, c_pen = 1'b0, c_podd = 1'b0, c_stop2 = 1'b0, c_sel = 1'b0;
    logic       txd, buf_empty, shift_done, tx_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int tdiv = 1;
    int tcnt = 0;
    bit tick_en = 1'b1;
    bit done_run = 1'b0;

    always #4 clk = ~clk;

    dbuf_uart_tx u_dbuf_uart_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len8(c_len8), .cfg_parity_en(c_pen), .cfg_parity_odd(c_podd),
        .cfg_stop2(c_stop2), .cfg_irq_on_done(c_sel),
        .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .tx_irq(tx_irq)
    );

    always @(negedge clk) begin
        if (tcnt >= tdiv - 1) begin
            baud_tick = tick_en;
            tcnt = 0;
        end else begin
            baud_tick = 1'b0;
            tcnt = tcnt + 1;
        end
        if (tx_irq) irq_cnt = irq_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int cpb();
        return 16 * tdiv;
    endfunction

    function automatic logic exp_parity(input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < (c_len8 ? 8 : 7); i++) ones += d[i];
        return logic'((ones % 2) ^ (c_podd ? 1 : 0));
    endfunction

    // Called at a negedge; the write is captured at the next posedge.
    task automatic pulse_write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // From idle: write, measure latency, return at first cycle of the start bit.
    task automatic start_char(input logic [7:0] d, input bit lat_chk);
        int n;
        @(negedge clk);
        pulse_write(d);
        chk(buf_empty == 1'b0, "R4 buf_empty after write", buf_empty, 0);
        n = 1;
        while (shift_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (lat_chk)
            chk(n >= 10 && n <= 25, "R7 start latency clocks", n, 17);
        chk(buf_empty == 1'b1, "R4 buf_empty at load", buf_empty, 1);
        chk(txd == 1'b0, "R7 start bit with fall of shift_done", txd, 0);
    endtask

    // Entered at mid of the start bit; leaves at mid of the last stop bit.
    task automatic check_frame(input logic [7:0] d);
        chk(txd == 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < (c_len8 ? 8 : 7); i++) begin
            repeat (cpb()) @(negedge clk);
            chk(txd == d[i], "R2 data bit", txd, d[i]);
        end
        if (c_pen) begin
            repeat (cpb()) @(negedge clk);
            chk(txd == exp_parity(d), "R3 parity bit", txd, exp_parity(d));
        end
        repeat (cpb()) @(negedge clk);
        chk(txd == 1'b1, "R2 first stop bit", txd, 1);
        chk(shift_done == 1'b0, "R6 shift_done low in first stop", shift_done, 0);
        if (c_stop2) begin
            repeat (cpb()) @(negedge clk);
            chk(txd == 1'b1, "R2 second stop bit", txd, 1);
            chk(shift_done == 1'b1, "R6 shift_done high in second stop", shift_done, 1);
        end
    endtask

    task automatic to_mid();
        repeat (cpb() / 2 - 1) @(negedge clk);
    endtask

    task automatic set_fmt(input int f, input bit odd, input bit sel);
        c_len8 = f[0];
        c_pen = f[1];
        c_stop2 = f[2];
        c_podd = odd;
        c_sel = sel;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(txd == 1'b1 && buf_empty && shift_done && !tx_irq, "R1 in reset",
            {txd, buf_empty, shift_done, tx_irq}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        chk(shift_done == 1'b1, "R1 shift_done", shift_done, 1);
        chk(tx_irq == 1'b0, "R1 tx_irq", tx_irq, 0);

        // Sweep of all eight formats, sixteen characters each, varying write phase.
        for (int f = 0; f < 8; f++) begin
            for (int k = 0; k < 16; k++) begin
                logic [7:0] d;
                d = 8'(k * 17 + f);
                set_fmt(f, k[1], k[0]);
                repeat (k) @(negedge clk);
                irq_cnt = 0;
                start_char(d, 1'b1);
                to_mid();
                check_frame(d);
                repeat (cpb() / 2 + 2) @(negedge clk);
                chk(shift_done == 1'b1 && txd == 1'b1, "R6 idle after frame",
                    {shift_done, txd}, 3);
                chk(irq_cnt == 1, "R9 one interrupt per frame", irq_cnt, 1);
            end
        end

        // R5: overwrite of a pending character.
        set_fmt(1, 1'b0, 1'b0);
        @(negedge clk);
        pulse_write(8'h3C);
        chk(buf_empty == 1'b0, "R5 pending", buf_empty, 0);
        pulse_write(8'hC5);
        while (txd) @(negedge clk);
        to_mid();
        check_frame(8'hC5);
        repeat (cpb()) @(negedge clk);

        // R8: back-to-back frames, one and two stop bits.
        for (int v = 0; v < 2; v++) begin
            set_fmt(v == 0 ? 1 : 6, 1'b0, 1'b1);
            irq_cnt = 0;
            start_char(8'hA6, 1'b1);
            pulse_write(8'h59);
            repeat (cpb() / 2 - 2) @(negedge clk);
            check_frame(8'hA6);
            repeat (cpb()) @(negedge clk);
            chk(txd == 1'b0, "R8 start bit directly after stop", txd, 0);
            if (!c_stop2)
                chk(irq_cnt == 0, "R8 shift_done stayed low across junction", irq_cnt, 0);
            chk(buf_empty == 1'b1, "R8 second character loaded", buf_empty, 1);
            check_frame(8'h59);
            repeat (cpb()) @(negedge clk);
            chk(irq_cnt == (c_stop2 ? 2 : 1), "R9 interrupts on shift_done", irq_cnt,
                c_stop2 ? 2 : 1);
        end

        // R10: stalled tick, then sparse ticks.
        set_fmt(3, 1'b1, 1'b0);
        start_char(8'h96, 1'b1);
        to_mid();
        tick_en = 1'b0;
        repeat (100) @(negedge clk);
        chk(txd == 1'b0 && !shift_done && buf_empty, "R10 held without ticks",
            {txd, shift_done, buf_empty}, 1);
        tick_en = 1'b1;
        check_frame(8'h96);
        repeat (cpb()) @(negedge clk);
        tdiv = 3;
        set_fmt(3, 1'b1, 1'b1);
        start_char(8'h4B, 1'b0);
        to_mid();
        check_frame(8'h4B);
        repeat (cpb()) @(negedge clk);
        chk(shift_done == 1'b1, "R10 frame done at sparse ticks", shift_done, 1);

        done_run = 1'b1;
        summary();
    end
endmodule